// File: doc/BRIEF.md
# Serial Management Register Slave

This block is the management-side endpoint of a PHY: it listens to a two-wire serial management bus (a host-driven clock, MDC, and one bidirectional data line, MDIO) and answers Clause 22 read and write frames that carry its PHY address. Behind the frame decoder sits a small register file. It holds the seven standard registers (control, status, two identifier words, advertisement, link-partner ability, expansion) and two vendor-range registers, an interrupt flag register and an interrupt enable register. Any other register address reads back as all ones.

The whole block runs on MDC with an asynchronous active-low reset. The data line is split into an input, an output value and an output enable, so the pad or the testbench builds the tri-state wire. Status values such as link state and partner ability come in as plain input levels. Interrupt events come in as one-cycle pulses that set sticky flags. The enabled flags are ORed onto a single interrupt output. Reading the flag register returns the flags and clears them in the same frame.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: A frame is accepted only after at least 32 consecutive ones sampled on rising MDC edges, followed by the start pair 0 then 1, a 2-bit opcode (10 = read, 01 = write), a 5-bit PHY address and a 5-bit register address, both MSB first, then two turnaround bits and 16 data bits MSB first.
- R2: On a matching read, the output enable stays low for the first turnaround bit and goes high driving 0 for the second. Data bits 15 down to 0 follow, each presented after a rising edge so the host samples it on the next one. The enable drops right after the edge that samples bit 0.
- R3: A frame whose PHY address differs from the 5-bit strap input never enables the output, never changes a register and never clears a flag.
- R4: A read of any register address other than 0 to 6, 29 and 30 returns 16'hFFFF.
- R5: Register 0 (control) and register 4 (advertisement) are fully writable and reset to 16'h3100 and 16'h01E1.
- R6: Register 1 reads {5'b01111, 5'b0, an_done, remote_fault, 1'b1, link_up, 1'b0, 1'b1}. Registers 2 and 3 read the identifier words 16'h01F0 and 16'h5A31. Register 5 reads lp_ability. Register 6 reads {11'b0, an_expansion}.
- R7: A write to registers 1, 2, 3, 5, 6, 29 or to any unimplemented address is discarded and changes no readable value.
- R8: Register 29 holds sticky flags in bits 7:1, set by irq_event[k] pulses into bit k+1, with the other bits reading 0. A read returns the flags captured at the first turnaround bit and clears them. A new event sampled on that same edge stays set.
- R9: Register 30 is the interrupt enable: only bits 7:1 are writable, other bits read 0, reset value 0. The irq output is high whenever a flag and its enable bit are both set.
- R10: A header whose opcode is 00 or 11, or a start pair that is not 01, abandons the frame. No output is driven and nothing changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock from the host; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdio_in | input | 1 | Value seen on the management data wire |
| mdio_out | output | 1 | Value the slave drives when enabled |
| mdio_oe | output | 1 | Output enable for the data wire |
| phy_addr | input | 5 | Strapped PHY address this slave answers to |
| link_up | input | 1 | Link state shown in register 1 bit 2 |
| an_done | input | 1 | Negotiation-complete level shown in register 1 bit 5 |
| remote_fault | input | 1 | Remote fault level shown in register 1 bit 4 |
| lp_ability | input | 16 | Partner ability word shown as register 5 |
| an_expansion | input | 5 | Expansion bits shown in register 6 bits 4:0 |
| irq_event | input | 7 | Event pulses; bit k sets flag bit k+1 of register 29 |
| irq | output | 1 | High when any enabled flag is set |

## Verification
Reads and writes go to every implemented address and to several unimplemented ones. This separates the real storage, the read-only mirrors of the inputs and the all-ones default. Frames with a foreign PHY address, an illegal opcode or a 31-bit preamble are sent between good frames, and a later read shows that none of them left a trace. An event is raised on the very edge where a flag read clears, which separates a design where clear wins from one where set wins. The output enable and data are compared on every bit period of every frame, so a turnaround or release that is one bit early or late shows up directly.

// File: rtl/mdio_slv_pkg.sv
package mdio_slv_pkg;

    localparam logic [1:0] OP_RD = 2'b10;
    localparam logic [1:0] OP_WR = 2'b01;

    localparam logic [4:0] RA_CTRL = 5'd0;
    localparam logic [4:0] RA_STAT = 5'd1;
    localparam logic [4:0] RA_IDHI = 5'd2;
    localparam logic [4:0] RA_IDLO = 5'd3;
    localparam logic [4:0] RA_ADV  = 5'd4;
    localparam logic [4:0] RA_LPA  = 5'd5;
    localparam logic [4:0] RA_EXP  = 5'd6;

    typedef enum logic [2:0] {
        FS_PRE,
        FS_START,
        FS_HDR,
        FS_TA,
        FS_DATA
    } frm_state_e;

endpackage

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_slv_pkg::*;
#(
    parameter int PRE_LEN = 32,
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 16
) (
    input  logic              mdc,
    input  logic              rst_n,
    input  logic              mdio_in,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              rd_stb,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              mdio_out,
    output logic              mdio_oe
);

    localparam int HDR_LEN = 2 + 2 * ADDR_W;
    localparam int ONES_W  = $clog2(PRE_LEN + 1);
    localparam int CNT_MAX = (DATA_W > HDR_LEN) ? DATA_W : HDR_LEN;
    localparam int CNT_W   = $clog2(CNT_MAX);

    typedef struct packed {
        frm_state_e        st;
        logic [ONES_W-1:0] ones;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] sh;
        logic              rd;
        logic              wr;
        logic [ADDR_W-1:0] ra;
        logic              oe;
        logic              dout;
    } fsm_t;

    localparam fsm_t FSM_RST = '{st: FS_PRE, default: '0};

    fsm_t q, d;
    logic [HDR_LEN-1:0] hdr;
    logic [1:0]         op;
    logic               hit;
    logic               op_ok;

    assign hdr   = {q.sh[HDR_LEN-2:0], mdio_in};
    assign op    = hdr[HDR_LEN-1 -: 2];
    assign hit   = (hdr[2*ADDR_W-1:ADDR_W] == phy_addr);
    assign op_ok = (op == OP_RD) || (op == OP_WR);

    always_comb begin
        d      = q;
        rd_stb = 1'b0;
        wr_stb = 1'b0;
        case (q.st)
            FS_PRE: begin
                d.oe = 1'b0;
                if (mdio_in) begin
                    if (q.ones != ONES_W'(PRE_LEN)) d.ones = q.ones + 1'b1;
                end else if (q.ones == ONES_W'(PRE_LEN)) begin
                    d.st   = FS_START;
                    d.ones = '0;
                end else begin
                    d.ones = '0;
                end
            end
            FS_START: begin
                if (mdio_in) begin
                    d.st  = FS_HDR;
                    d.cnt = '0;
                end else begin
                    d.st = FS_PRE;
                end
            end
            FS_HDR: begin
                d.sh  = {q.sh[DATA_W-2:0], mdio_in};
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == CNT_W'(HDR_LEN - 1)) begin
                    d.cnt = '0;
                    d.ra  = hdr[ADDR_W-1:0];
                    d.rd  = (op == OP_RD) && hit;
                    d.wr  = (op == OP_WR) && hit;
                    d.st  = op_ok ? FS_TA : FS_PRE;
                end
            end
            FS_TA: begin
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == '0) begin
                    if (q.rd) begin
                        rd_stb = 1'b1;
                        d.oe   = 1'b1;
                        d.dout = 1'b0;
                        d.sh   = rd_data;
                    end
                end else begin
                    d.st  = FS_DATA;
                    d.cnt = '0;
                    if (q.rd) begin
                        d.dout = q.sh[DATA_W-1];
                        d.sh   = {q.sh[DATA_W-2:0], 1'b0};
                    end
                end
            end
            FS_DATA: begin
                d.cnt = q.cnt + 1'b1;
                if (q.rd) begin
                    d.dout = q.sh[DATA_W-1];
                    d.sh   = {q.sh[DATA_W-2:0], 1'b0};
                end else begin
                    d.sh = {q.sh[DATA_W-2:0], mdio_in};
                end
                if (q.cnt == CNT_W'(DATA_W - 1)) begin
                    d.st   = FS_PRE;
                    d.ones = '0;
                    d.oe   = 1'b0;
                    d.dout = 1'b0;
                    wr_stb = q.wr;
                end
            end
            default: d = FSM_RST;
        endcase
    end

    always_ff @(posedge mdc or negedge rst_n) begin
        if (!rst_n) q <= FSM_RST;
        else        q <= d;
    end

    assign reg_addr = q.ra;
    assign wr_data  = {q.sh[DATA_W-2:0], mdio_in};
    assign mdio_out = q.dout;
    assign mdio_oe  = q.oe;

    // R2: the enable rises only to drive the zero turnaround bit
    a_r2_ta_low: assert property (@(posedge mdc) disable iff (!rst_n)
        $rose(mdio_oe) |-> !mdio_out);

    // R2: release right after the edge that samples the last data bit
    a_r2_release: assert property (@(posedge mdc) disable iff (!rst_n)
        (q.st == FS_DATA && q.cnt == CNT_W'(DATA_W - 1)) |=> !mdio_oe);

    // R3: the line is only driven for a read that matched the strap
    a_r3_drive_only_hit: assert property (@(posedge mdc) disable iff (!rst_n)
        mdio_oe |-> (q.rd && (q.st == FS_TA || q.st == FS_DATA)));

    // R1: a start bit is only looked for after a full preamble
    a_r1_full_preamble: assert property (@(posedge mdc) disable iff (!rst_n)
        (q.st == FS_START) |-> ($past(q.ones) == ONES_W'(PRE_LEN)));

    // R10: an illegal opcode sends the decoder back to preamble hunting
    a_r10_bad_op: assert property (@(posedge mdc) disable iff (!rst_n)
        (q.st == FS_HDR && q.cnt == CNT_W'(HDR_LEN - 1) && !op_ok)
        |=> (q.st == FS_PRE && !mdio_oe));

endmodule

// File: rtl/mdio_reg_file.sv
module mdio_reg_file
    import mdio_slv_pkg::*;
#(
    parameter int          ADDR_W   = 5,
    parameter int          DATA_W   = 16,
    parameter int          IRQ_N    = 7,
    parameter logic [4:0]  SRC_ADDR = 5'd29,
    parameter logic [4:0]  MSK_ADDR = 5'd30,
    parameter logic [15:0] CTRL_RST = 16'h3100,
    parameter logic [15:0] ADV_RST  = 16'h01E1,
    parameter logic [15:0] ID_HI    = 16'h01F0,
    parameter logic [15:0] ID_LO    = 16'h5A31,
    parameter logic [4:0]  ABILITY  = 5'b01111
) (
    input  logic              mdc,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              link_up,
    input  logic              an_done,
    input  logic              remote_fault,
    input  logic [DATA_W-1:0] lp_ability,
    input  logic [4:0]        an_expansion,
    input  logic [IRQ_N-1:0]  irq_event,
    output logic              irq
);

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] adv;
        logic [IRQ_N-1:0]  msk;
        logic [IRQ_N-1:0]  src;
    } regs_t;

    localparam regs_t REGS_RST = '{ctrl: CTRL_RST, adv: ADV_RST, default: '0};

    regs_t q, d;
    logic  src_clr;

    assign src_clr = rd_stb && (reg_addr == SRC_ADDR);

    always_comb begin
        d = q;
        for (int i = 0; i < IRQ_N; i++) begin
            d.src[i] = (q.src[i] && !src_clr) || irq_event[i];
        end
        if (wr_stb) begin
            case (reg_addr)
                RA_CTRL:  d.ctrl = wr_data;
                RA_ADV:   d.adv  = wr_data;
                MSK_ADDR: d.msk  = wr_data[IRQ_N:1];
                default:  ;
            endcase
        end
    end

    always_comb begin
        rd_data = '1;
        case (reg_addr)
            RA_CTRL: rd_data = q.ctrl;
            RA_STAT: rd_data = {ABILITY, 5'b0, an_done, remote_fault, 1'b1, link_up, 1'b0, 1'b1};
            RA_IDHI: rd_data = ID_HI;
            RA_IDLO: rd_data = ID_LO;
            RA_ADV:  rd_data = q.adv;
            RA_LPA:  rd_data = lp_ability;
            RA_EXP:  rd_data = {{(DATA_W-5){1'b0}}, an_expansion};
            SRC_ADDR: begin
                rd_data = '0;
                rd_data[IRQ_N:1] = q.src;
            end
            MSK_ADDR: begin
                rd_data = '0;
                rd_data[IRQ_N:1] = q.msk;
            end
            default: rd_data = '1;
        endcase
    end

    always_ff @(posedge mdc or negedge rst_n) begin
        if (!rst_n) q <= REGS_RST;
        else        q <= d;
    end

    assign irq = |(q.src & q.msk);

    // R8: a flag read with no fresh event leaves the register empty
    a_r8_clear_on_read: assert property (@(posedge mdc) disable iff (!rst_n)
        (src_clr && irq_event == '0) |=> (q.src == '0));

    // R8: a fresh event always lands, even on the clearing edge
    a_r8_set_wins: assert property (@(posedge mdc) disable iff (!rst_n)
        (irq_event != '0) |=> ((q.src & $past(irq_event)) == $past(irq_event)));

    // R7: writes outside the writable set touch no storage
    a_r7_ro_write: assert property (@(posedge mdc) disable iff (!rst_n)
        (wr_stb && reg_addr != RA_CTRL && reg_addr != RA_ADV && reg_addr != MSK_ADDR)
        |=> ($stable(q.ctrl) && $stable(q.adv) && $stable(q.msk)));

    // R9: an enable write keeps exactly bits 7:1
    a_r9_mask_write: assert property (@(posedge mdc) disable iff (!rst_n)
        (wr_stb && reg_addr == MSK_ADDR) |=> (q.msk == $past(wr_data[IRQ_N:1])));

endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave #(
    parameter int PRE_LEN = 32,
    parameter int IRQ_N   = 7
) (
    input  logic             mdc,
    input  logic             rst_n,
    input  logic             mdio_in,
    output logic             mdio_out,
    output logic             mdio_oe,
    input  logic [4:0]       phy_addr,
    input  logic             link_up,
    input  logic             an_done,
    input  logic             remote_fault,
    input  logic [15:0]      lp_ability,
    input  logic [4:0]       an_expansion,
    input  logic [IRQ_N-1:0] irq_event,
    output logic             irq
);

    localparam int ADDR_W = 5;
    localparam int DATA_W = 16;

    logic [ADDR_W-1:0] reg_addr;
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] wr_data;
    logic              rd_stb;
    logic              wr_stb;

    mdio_frame_fsm #(
        .PRE_LEN (PRE_LEN),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W)
    ) i_fsm (
        .mdc      (mdc),
        .rst_n    (rst_n),
        .mdio_in  (mdio_in),
        .phy_addr (phy_addr),
        .rd_data  (rd_data),
        .rd_stb   (rd_stb),
        .wr_stb   (wr_stb),
        .reg_addr (reg_addr),
        .wr_data  (wr_data),
        .mdio_out (mdio_out),
        .mdio_oe  (mdio_oe)
    );

    mdio_reg_file #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .IRQ_N  (IRQ_N)
    ) i_regs (
        .mdc          (mdc),
        .rst_n        (rst_n),
        .reg_addr     (reg_addr),
        .rd_stb       (rd_stb),
        .wr_stb       (wr_stb),
        .wr_data      (wr_data),
        .rd_data      (rd_data),
        .link_up      (link_up),
        .an_done      (an_done),
        .remote_fault (remote_fault),
        .lp_ability   (lp_ability),
        .an_expansion (an_expansion),
        .irq_event    (irq_event),
        .irq          (irq)
    );

endmodule

// File: tb/test_mdio_mgmt_slave.sv
module test_mdio_mgmt_slave;

    logic        mdc = 1'b0;
    logic        rst_n;
    logic        host_bit;
    logic        mdio_w;
    logic        mdio_out;
    logic        mdio_oe;
    logic [4:0]  strap;
    logic        link_up;
    logic        an_done;
    logic        rfault;
    logic [15:0] lpa;
    logic [4:0]  anexp;
    logic [6:0]  ev;
    logic        irq;

    int vectors = 0;
    int fails   = 0;

    // reference state
    logic [15:0] m_ctrl;
    logic [15:0] m_adv;
    logic [7:0]  m_msk;
    logic [7:0]  m_src;

    always #5 mdc = ~mdc;

    assign mdio_w = mdio_oe ? mdio_out : host_bit;

    mdio_mgmt_slave i_mdio_mgmt_slave (
        .mdc          (mdc),
        .rst_n        (rst_n),
        .mdio_in      (mdio_w),
        .mdio_out     (mdio_out),
        .mdio_oe      (mdio_oe),
        .phy_addr     (strap),
        .link_up      (link_up),
        .an_done      (an_done),
        .remote_fault (rfault),
        .lp_ability   (lpa),
        .an_expansion (anexp),
        .irq_event    (ev),
        .irq          (irq)
    );

    function automatic logic [15:0] m_read(input logic [4:0] a);
        case (a)
            5'd0:    return m_ctrl;
            5'd1:    return {5'b01111, 5'b0, an_done, rfault, 1'b1, link_up, 1'b0, 1'b1};
            5'd2:    return 16'h01F0;
            5'd3:    return 16'h5A31;
            5'd4:    return m_adv;
            5'd5:    return lpa;
            5'd6:    return {11'b0, anexp};
            5'd29:   return {8'h00, m_src[7:1], 1'b0};
            5'd30:   return {8'h00, m_msk[7:1], 1'b0};
            default: return 16'hFFFF;
        endcase
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge mdc);
            chk("R2 idle oe", {15'b0, mdio_oe}, 16'h0000);
            chk("R9 irq", {15'b0, irq}, {15'b0, |(m_src & m_msk)});
            host_bit = 1'b0;
            ev       = '0;
        end
    endtask

    task automatic pulse(input logic [6:0] e);
        @(negedge mdc);
        chk("R9 irq", {15'b0, irq}, {15'b0, |(m_src & m_msk)});
        ev       = e;
        m_src    = m_src | {e, 1'b0};
        host_bit = 1'b0;
        idle(2);
    endtask

    // one complete frame, outputs compared in every bit period
    task automatic frame(input string req, input logic [1:0] op, input logic [4:0] phy,
                         input logic [4:0] ra, input logic [15:0] wd, input int pre,
                         input logic [6:0] ev_ta);
        logic [15:0] rexp;
        logic        hit;
        logic        rd;
        logic        wr;
        int          total;
        hit   = (phy == strap) && (pre >= 32);
        rd    = hit && (op == 2'b10);
        wr    = hit && (op == 2'b01);
        total = pre + 32;
        for (int i = 0; i < total; i++) begin
            int   j;
            logic b;
            logic eoe;
            @(negedge mdc);
            j   = i - pre;
            eoe = rd && (j >= 15);
            chk(req, {15'b0, mdio_oe}, {15'b0, eoe});
            if (eoe) begin
                if (j == 15) chk(req, {15'b0, mdio_out}, 16'h0000);
                else         chk(req, {15'b0, mdio_out}, {15'b0, rexp[31-j]});
            end
            chk("R9 irq", {15'b0, irq}, {15'b0, |(m_src & m_msk)});
            if (i < pre)       b = 1'b1;
            else if (j == 0)   b = 1'b0;
            else if (j == 1)   b = 1'b1;
            else if (j < 4)    b = op[3-j];
            else if (j < 9)    b = phy[8-j];
            else if (j < 14)   b = ra[13-j];
            else if (j == 14)  b = 1'b1;
            else if (j == 15)  b = (op == 2'b01) ? 1'b0 : 1'b1;
            else               b = (op == 2'b01) ? wd[31-j] : 1'b1;
            host_bit = b;
            ev       = '0;
            if (j == 12) rexp = m_read(ra);
            if (j == 14) begin
                ev = ev_ta;
                if (rd && ra == 5'd29) m_src = {ev_ta, 1'b0};
                else                   m_src = m_src | {ev_ta, 1'b0};
            end
            if (j == 31 && wr) begin
                case (ra)
                    5'd0:    m_ctrl = wd;
                    5'd4:    m_adv  = wd;
                    5'd30:   m_msk  = {wd[7:1], 1'b0};
                    default: ;
                endcase
            end
        end
        idle(2);
    endtask

    task automatic rd_chk(input string req, input logic [4:0] ra);
        frame(req, 2'b10, strap, ra, 16'h0000, 32, 7'h00);
    endtask

    task automatic wr_do(input string req, input logic [4:0] ra, input logic [15:0] wd);
        frame(req, 2'b01, strap, ra, wd, 32, 7'h00);
    endtask

    logic done = 1'b0;

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        rst_n    = 1'b0;
        host_bit = 1'b0;
        strap    = 5'd9;
        link_up  = 1'b0;
        an_done  = 1'b0;
        rfault   = 1'b0;
        lpa      = 16'h0000;
        anexp    = 5'd0;
        ev       = '0;
        m_ctrl   = 16'h3100;
        m_adv    = 16'h01E1;
        m_msk    = 8'h00;
        m_src    = 8'h00;
        repeat (3) @(negedge mdc);
        chk("R2 reset oe", {15'b0, mdio_oe}, 16'h0000);
        chk("R9 reset irq", {15'b0, irq}, 16'h0000);
        rst_n = 1'b1;
        idle(3);

        // R5 reset values
        rd_chk("R5 ctrl reset", 5'd0);
        rd_chk("R5 adv reset", 5'd4);
        rd_chk("R9 mask reset", 5'd30);

        // R6 mirrored inputs and identifiers
        link_up = 1'b1; an_done = 1'b1; lpa = 16'hC5E1; anexp = 5'b10011;
        rd_chk("R6 status", 5'd1);
        rfault = 1'b1; link_up = 1'b0;
        rd_chk("R6 status fault", 5'd1);
        rd_chk("R6 id hi", 5'd2);
        rd_chk("R6 id lo", 5'd3);
        rd_chk("R6 lp ability", 5'd5);
        rd_chk("R6 expansion", 5'd6);

        // R1 R5 writable storage
        wr_do("R5 ctrl write", 5'd0, 16'h1234);
        rd_chk("R5 ctrl readback", 5'd0);
        wr_do("R5 adv write", 5'd4, 16'hABCD);
        rd_chk("R5 adv readback", 5'd4);
        frame("R1 long preamble", 2'b10, strap, 5'd0, 16'h0, 45, 7'h00);

        // R7 discarded writes
        wr_do("R7 write status", 5'd1, 16'h0000);
        wr_do("R7 write id", 5'd2, 16'hFFFF);
        wr_do("R7 write src", 5'd29, 16'h00FE);
        wr_do("R7 write unimpl", 5'd12, 16'h0F0F);
        rd_chk("R7 status kept", 5'd1);
        rd_chk("R7 id kept", 5'd2);
        rd_chk("R7 src kept", 5'd29);
        rd_chk("R7 ctrl kept", 5'd0);

        // R4 unimplemented reads
        rd_chk("R4 addr 7", 5'd7);
        rd_chk("R4 addr 15", 5'd15);
        rd_chk("R4 addr 28", 5'd28);
        rd_chk("R4 addr 31", 5'd31);

        // R3 foreign PHY address
        frame("R3 foreign read", 2'b10, 5'd3, 5'd0, 16'h0, 32, 7'h00);
        frame("R3 foreign write", 2'b01, 5'd10, 5'd0, 16'h5555, 32, 7'h00);
        rd_chk("R3 ctrl kept", 5'd0);

        // R9 enable register
        wr_do("R9 mask write", 5'd30, 16'hFFFF);
        rd_chk("R9 mask readback", 5'd30);

        // R8 flags
        pulse(7'b0000101);
        rd_chk("R8 flags read", 5'd29);
        rd_chk("R8 flags cleared", 5'd29);
        pulse(7'b0100000);
        frame("R3 foreign src read", 2'b10, 5'd8, 5'd29, 16'h0, 32, 7'h00);
        rd_chk("R3 R8 flags kept", 5'd29);
        pulse(7'b0000001);
        frame("R8 set wins", 2'b10, strap, 5'd29, 16'h0, 32, 7'b1000000);
        rd_chk("R8 late event kept", 5'd29);

        // R9 masking
        pulse(7'b0010010);
        wr_do("R9 mask off", 5'd30, 16'h0000);
        wr_do("R9 mask one", 5'd30, 16'h0004);
        wr_do("R9 mask hit", 5'd30, 16'h0020);
        rd_chk("R9 flags with mask", 5'd29);

        // R10 bad opcode and R1 short preamble
        frame("R10 op 11", 2'b11, strap, 5'd0, 16'h7777, 32, 7'h00);
        frame("R10 op 00", 2'b00, strap, 5'd4, 16'h0000, 32, 7'h00);
        frame("R1 short preamble", 2'b01, strap, 5'd0, 16'hA5A5, 31, 7'h00);
        rd_chk("R10 ctrl kept", 5'd0);
        rd_chk("R10 adv kept", 5'd4);

        // R3 different strap
        strap = 5'd0;
        wr_do("R3 strap zero write", 5'd4, 16'h0E21);
        rd_chk("R3 strap zero read", 5'd4);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule